// File: doc/BRIEF.md
# Key-Protected Nonvolatile Memory Command Controller

This block sits between a small processor's register bus and the write and erase ports of an on-chip flash array and an EEPROM array. Software first writes an unlock key and then has a short window, counted in retired instructions, in which it may write a command code. Two codes, whole-flash erase and whole-EEPROM erase, launch their operation as soon as they are written. The remaining write and erase codes only arm the controller. After that, every store that reaches the matching memory region becomes a single write or page-erase strobe. The armed state holds until a no-operation code replaces it.

Stores come in on a valid/ready stream. `st_ready` is low while either memory is busy. A store is taken in the cycle where `st_valid` and `st_ready` are both high. The producer must hold the store and its address steady until that cycle. Each accepted store produces at most one outcome: a flash write, a flash page erase, an EEPROM write, a rejection, or nothing.

Each memory has a busy flag. It rises with that memory's launch strobe and falls after a one-cycle done pulse from the memory. A mapping register chooses which 32 KB flash section the upper half of the data address space reaches.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: Writing 0x9D to register address 0 opens a window that lasts four `retire` pulses. A command write to register address 1 is accepted only while the window is open and both busy flags are clear. Any write to address 1 closes the window.
- R2: A command write made with the window closed, or while either busy flag is set, leaves the command register unchanged and sets the sticky error bit, status bit 2. Writing register address 2 with bit 2 set clears the error bit.
- R3: The known command codes are:
  - 0x00: none
  - 0x01: no-op
  - 0x02: flash write
  - 0x03: flash page erase
  - 0x10: EEPROM write
  - 0x20: flash whole erase
  - 0x30: EEPROM whole erase

  Any other code written inside an open window leaves the command register unchanged and does not set the error bit.
- R4: An accepted 0x20 raises `fl_ce_stb` for one cycle, and an accepted 0x30 raises `ee_ce_stb` for one cycle. Either strobe appears in the cycle after the write, and no store is needed.
- R5: While the command register holds 0x02, each accepted store to a flash target gives one `fl_wr_stb` pulse. With 0x03 the pulse is on `fl_pe_stb`. With 0x10, each accepted store in the EEPROM region (0x1400 to 0x14FF) gives one `ee_wr_stb` pulse. The command stays armed across any number of stores. `wr_data` carries the stored byte.
- R6: While the command register holds 0x00 or 0x01, accepted stores produce no strobe.
- R7: Status bit 0 is the flash busy flag and status bit 1 is the EEPROM busy flag. A flag rises in the same cycle as its memory's launch strobe. It clears in the cycle after a done pulse. `st_ready` is low while either flag is set.
- R8: A data store at 0x8000 to 0xFFFF, or a program-style store (`st_pm` high) outside the EEPROM region, targets flash. Its address is `{map, st_addr[14:0]}`, where `map` is bits [1:0] of register address 3.
- R9: A program-style store to the EEPROM region raises `st_reject` for one cycle and produces no write strobe.
- R10: Reads return the following:
  - address 0: zero
  - address 1: the command register
  - address 2: `{5'b0, error, ee_busy, fl_busy}`
  - address 3: the map field

  All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on `bus_addr`) |
| retire | input | 1 | One pulse per retired instruction |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request can be taken |
| st_addr | input | 16 | Store address in the data or program space |
| st_data | input | 8 | Store data byte |
| st_pm | input | 1 | Store is program-memory style |
| fl_done | input | 1 | Flash operation finished (one cycle) |
| ee_done | input | 1 | EEPROM operation finished (one cycle) |
| fl_wr_stb | output | 1 | Flash byte write strobe |
| fl_pe_stb | output | 1 | Flash page erase strobe |
| fl_ce_stb | output | 1 | Flash whole-array erase strobe |
| fl_addr | output | MAP_W+15 | Flash byte address |
| ee_wr_stb | output | 1 | EEPROM write strobe |
| ee_ce_stb | output | 1 | EEPROM whole-array erase strobe |
| ee_addr | output | EE_AW | EEPROM byte address |
| wr_data | output | 8 | Data for the write strobes |
| st_reject | output | 1 | Program-style store to EEPROM refused |

## Verification
Register reads and `st_ready` are combinational, so the bench samples them one time unit after it drives inputs on the falling edge, before the next rising edge. Command, error, window, map and busy state change on the rising edge where the write, store or done pulse is sampled. Every strobe, address and `wr_data` value appears after that same edge, so each is checked on the following falling edge. A bench model advanced at each rising edge supplies the expected values. Directed steps then read registers one cycle later to confirm R1 to R3 and R7.

// File: rtl/nvm_ctrl_pkg.sv
package nvm_ctrl_pkg;

  typedef enum logic [7:0] {
    OP_NONE         = 8'h00,
    OP_IDLE         = 8'h01,
    OP_FL_WRITE     = 8'h02,
    OP_FL_PGERASE   = 8'h03,
    OP_EE_WRITE     = 8'h10,
    OP_FL_WHOLE     = 8'h20,
    OP_EE_WHOLE     = 8'h30
  } nvm_op_e;

  typedef enum logic [1:0] {
    RA_KEY  = 2'd0,
    RA_CMD  = 2'd1,
    RA_STAT = 2'd2,
    RA_MAP  = 2'd3
  } reg_addr_e;

  localparam logic [7:0] UNLOCK_KEY   = 8'h9D;
  localparam int         SECT_BITS    = 15;
  localparam int         ERR_CLR_BIT  = 2;

  function automatic logic op_known(input logic [7:0] code);
    case (code)
      OP_NONE, OP_IDLE, OP_FL_WRITE, OP_FL_PGERASE,
      OP_EE_WRITE, OP_FL_WHOLE, OP_EE_WHOLE: return 1'b1;
      default:                               return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nvm_key_window.sv
module nvm_key_window #(
  parameter int WIN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  input  logic consume,
  input  logic retire,
  output logic open
);
  localparam int CW = $clog2(WIN_LEN + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (key_hit) begin
      left_q <= CW'(WIN_LEN);
    end else if (consume) begin
      left_q <= '0;
    end else if (retire && left_q != '0) begin
      left_q <= left_q - CW'(1);
    end
  end

  assign open = (left_q != '0);
endmodule

// File: rtl/nvm_cmd_regs.sv
module nvm_cmd_regs
  import nvm_ctrl_pkg::*;
#(
  parameter int MAP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             win_open,
  input  logic             any_busy,
  output logic             cmd_wr,
  output logic [7:0]       cmd_q,
  output logic             err_q,
  output logic [MAP_W-1:0] map_q,
  output logic             fl_whole_go,
  output logic             ee_whole_go
);
  logic allowed;
  logic clr_err;

  assign cmd_wr      = bus_wr && (bus_addr == RA_CMD);
  assign allowed     = cmd_wr && win_open && !any_busy;
  assign clr_err     = bus_wr && (bus_addr == RA_STAT) && bus_wdata[ERR_CLR_BIT];
  assign fl_whole_go = allowed && (bus_wdata == OP_FL_WHOLE);
  assign ee_whole_go = allowed && (bus_wdata == OP_EE_WHOLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= OP_NONE;
      err_q <= 1'b0;
      map_q <= '0;
    end else begin
      if (allowed && op_known(bus_wdata)) begin
        cmd_q <= bus_wdata;
      end
      if (cmd_wr && !allowed) begin
        err_q <= 1'b1;
      end else if (clr_err) begin
        err_q <= 1'b0;
      end
      if (bus_wr && bus_addr == RA_MAP) begin
        map_q <= bus_wdata[MAP_W-1:0];
      end
    end
  end
endmodule

// File: rtl/nvm_store_gate.sv
module nvm_store_gate
  import nvm_ctrl_pkg::*;
#(
  parameter int          MAP_W   = 2,
  parameter int          EE_AW   = 8,
  parameter logic [15:0] EE_BASE = 16'h1400
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic [15:0]              st_addr,
  input  logic [7:0]               st_data,
  input  logic                     st_pm,
  input  logic [7:0]               cmd,
  input  logic [MAP_W-1:0]         map,
  output logic                     fl_go,
  output logic                     ee_go,
  output logic                     fl_wr_stb,
  output logic                     fl_pe_stb,
  output logic                     ee_wr_stb,
  output logic                     reject,
  output logic [MAP_W+SECT_BITS-1:0] fl_addr,
  output logic [EE_AW-1:0]         ee_addr,
  output logic [7:0]               wr_data
);
  logic in_ee, to_flash, to_ee;
  logic fl_wr_go, fl_pe_go, rej_go;

  assign in_ee    = (st_addr[15:EE_AW] == EE_BASE[15:EE_AW]);
  assign to_flash = st_pm ? !in_ee : st_addr[15];
  assign to_ee    = !st_pm && in_ee;

  assign rej_go   = accept && st_pm && in_ee;
  assign fl_wr_go = accept && to_flash && (cmd == OP_FL_WRITE);
  assign fl_pe_go = accept && to_flash && (cmd == OP_FL_PGERASE);
  assign ee_go    = accept && to_ee && (cmd == OP_EE_WRITE);
  assign fl_go    = fl_wr_go || fl_pe_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_wr_stb <= 1'b0;
      fl_pe_stb <= 1'b0;
      ee_wr_stb <= 1'b0;
      reject    <= 1'b0;
      fl_addr   <= '0;
      ee_addr   <= '0;
      wr_data   <= '0;
    end else begin
      fl_wr_stb <= fl_wr_go;
      fl_pe_stb <= fl_pe_go;
      ee_wr_stb <= ee_go;
      reject    <= rej_go;
      if (fl_go) begin
        fl_addr <= {map, st_addr[SECT_BITS-1:0]};
      end
      if (ee_go) begin
        ee_addr <= st_addr[EE_AW-1:0];
      end
      if (fl_go || ee_go) begin
        wr_data <= st_data;
      end
    end
  end
endmodule

// File: rtl/nvm_busy_flag.sv
module nvm_busy_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic done,
  output logic busy
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (launch) begin
      busy <= 1'b1;
    end else if (done) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/nvm_cmd_ctrl.sv
module nvm_cmd_ctrl
  import nvm_ctrl_pkg::*;
#(
  parameter int          MAP_W   = 2,
  parameter int          EE_AW   = 8,
  parameter logic [15:0] EE_BASE = 16'h1400,
  parameter int          WIN_LEN = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [1:0]                 bus_addr,
  input  logic [7:0]                 bus_wdata,
  output logic [7:0]                 bus_rdata,
  input  logic                       retire,
  input  logic                       st_valid,
  output logic                       st_ready,
  input  logic [15:0]                st_addr,
  input  logic [7:0]                 st_data,
  input  logic                       st_pm,
  input  logic                       fl_done,
  input  logic                       ee_done,
  output logic                       fl_wr_stb,
  output logic                       fl_pe_stb,
  output logic                       fl_ce_stb,
  output logic [MAP_W+SECT_BITS-1:0] fl_addr,
  output logic                       ee_wr_stb,
  output logic                       ee_ce_stb,
  output logic [EE_AW-1:0]           ee_addr,
  output logic [7:0]                 wr_data,
  output logic                       st_reject
);
  localparam int NMEM = 2;

  logic             win_open, cmd_wr, key_hit;
  logic [7:0]       cmd_q;
  logic             wr_err;
  logic [MAP_W-1:0] map_q;
  logic             fl_whole_go, ee_whole_go;
  logic             fl_go, ee_go, accept;
  logic             fl_busy, ee_busy, any_busy;
  logic [NMEM-1:0]  launch_v, done_v, busy_v;

  assign key_hit  = bus_wr && (bus_addr == RA_KEY) && (bus_wdata == UNLOCK_KEY);
  assign any_busy = fl_busy || ee_busy;
  assign st_ready = !any_busy;
  assign accept   = st_valid && st_ready;

  nvm_key_window #(.WIN_LEN(WIN_LEN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_hit (key_hit),
    .consume (cmd_wr),
    .retire  (retire),
    .open    (win_open)
  );

  nvm_cmd_regs #(.MAP_W(MAP_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .win_open    (win_open),
    .any_busy    (any_busy),
    .cmd_wr      (cmd_wr),
    .cmd_q       (cmd_q),
    .err_q       (wr_err),
    .map_q       (map_q),
    .fl_whole_go (fl_whole_go),
    .ee_whole_go (ee_whole_go)
  );

  nvm_store_gate #(.MAP_W(MAP_W), .EE_AW(EE_AW), .EE_BASE(EE_BASE)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .st_addr   (st_addr),
    .st_data   (st_data),
    .st_pm     (st_pm),
    .cmd       (cmd_q),
    .map       (map_q),
    .fl_go     (fl_go),
    .ee_go     (ee_go),
    .fl_wr_stb (fl_wr_stb),
    .fl_pe_stb (fl_pe_stb),
    .ee_wr_stb (ee_wr_stb),
    .reject    (st_reject),
    .fl_addr   (fl_addr),
    .ee_addr   (ee_addr),
    .wr_data   (wr_data)
  );

  assign launch_v = {ee_go || ee_whole_go, fl_go || fl_whole_go};
  assign done_v   = {ee_done, fl_done};

  for (genvar m = 0; m < NMEM; m++) begin : g_busy
    nvm_busy_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch_v[m]),
      .done   (done_v[m]),
      .busy   (busy_v[m])
    );
  end

  assign fl_busy = busy_v[0];
  assign ee_busy = busy_v[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_ce_stb <= 1'b0;
      ee_ce_stb <= 1'b0;
    end else begin
      fl_ce_stb <= fl_whole_go;
      ee_ce_stb <= ee_whole_go;
    end
  end

  always_comb begin
    unique case (bus_addr)
      RA_KEY:  bus_rdata = 8'h00;
      RA_CMD:  bus_rdata = cmd_q;
      RA_STAT: bus_rdata = {5'b0, wr_err, ee_busy, fl_busy};
      RA_MAP:  bus_rdata = 8'(map_q);
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
module nvm_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic       st_ready,
  input logic       fl_done,
  input logic       ee_done,
  input logic       fl_wr_stb,
  input logic       fl_pe_stb,
  input logic       fl_ce_stb,
  input logic       ee_wr_stb,
  input logic       ee_ce_stb,
  input logic       st_reject,
  input logic       fl_busy,
  input logic       ee_busy,
  input logic       wr_err
);
  p_fl_busy_with_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ce_stb || fl_wr_stb || fl_pe_stb) |-> fl_busy);

  p_ee_busy_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_ce_stb || ee_wr_stb) |-> ee_busy);

  p_ready_low_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_busy || ee_busy) |-> !st_ready);

  p_fl_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_busy && fl_done) |=> !fl_busy);

  p_ee_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_busy && ee_done) |=> !ee_busy);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_wr_stb, fl_pe_stb, ee_wr_stb, st_reject}));

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !(bus_wr && bus_addr == 2'd2 && bus_wdata[2])) |=> wr_err);

  p_whole_erase_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_ce_stb || ee_ce_stb) |=> !(fl_ce_stb || ee_ce_stb));
endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .st_ready  (st_ready),
  .fl_done   (fl_done),
  .ee_done   (ee_done),
  .fl_wr_stb (fl_wr_stb),
  .fl_pe_stb (fl_pe_stb),
  .fl_ce_stb (fl_ce_stb),
  .ee_wr_stb (ee_wr_stb),
  .ee_ce_stb (ee_ce_stb),
  .st_reject (st_reject),
  .fl_busy   (fl_busy),
  .ee_busy   (ee_busy),
  .wr_err    (wr_err)
);

// File: tb/nvm_cmd_ctrl_tb.sv
module nvm_cmd_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FAW = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 0, retire = 0, st_valid = 0, st_pm = 0, fl_done = 0, ee_done = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, st_data = 0, bus_rdata, wr_data;
  logic [15:0] st_addr = 0;
  logic st_ready, fl_wr_stb, fl_pe_stb, fl_ce_stb, ee_wr_stb, ee_ce_stb, st_reject;
  logic [FAW-1:0] fl_addr;
  logic [7:0] ee_addr;

  int checks = 0, errs = 0;
  bit finished = 0;

  // bench model state
  int m_cnt = 0;
  logic [7:0] m_cmd = 0;
  logic m_err = 0, m_fb = 0, m_eb = 0;
  logic [1:0] m_map = 0;
  logic e_fw, e_fpe, e_fce, e_ew, e_ece, e_rej;
  logic [FAW-1:0] e_faddr = 0;
  logic [7:0] e_eaddr = 0, e_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvm_cmd_ctrl dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic known(input logic [7:0] c);
    return c == 8'h00 || c == 8'h01 || c == 8'h02 || c == 8'h03 ||
           c == 8'h10 || c == 8'h20 || c == 8'h30;
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd1:    return m_cmd;
      2'd2:    return {5'b0, m_err, m_eb, m_fb};
      2'd3:    return {6'b0, m_map};
      default: return 8'h00;
    endcase
  endfunction

  // one cycle: drive at falling edge, check combinational outputs,
  // advance model at rising edge, check registered outputs at next falling edge
  task automatic cycle(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input logic ret, input logic sv, input logic [15:0] sa,
                       input logic pm, input logic fd, input logic ed);
    logic busy, open, acc, in_ee, fl_t;
    int n_cnt;
    logic [7:0] n_cmd;
    logic n_err;
    logic [1:0] n_map;
    logic [7:0] sd;
    sd = 8'($urandom);
    bus_wr = wr; bus_addr = a; bus_wdata = d; retire = ret;
    st_valid = sv; st_addr = sa; st_pm = pm; st_data = sd;
    fl_done = fd; ee_done = ed;
    #1;
    chk(32'(st_ready), 32'(!(m_fb || m_eb)), "R7 st_ready");
    chk(32'(bus_rdata), 32'(exp_rdata(a)), "R10 rdata");
    @(posedge clk);
    busy = m_fb || m_eb; open = (m_cnt != 0); acc = sv && !busy;
    {e_fw, e_fpe, e_fce, e_ew, e_ece, e_rej} = '0;
    n_cnt = m_cnt; n_cmd = m_cmd; n_err = m_err; n_map = m_map;
    in_ee = (sa[15:8] == 8'h14);
    fl_t  = pm ? !in_ee : sa[15];
    if (acc) begin
      if (pm && in_ee) e_rej = 1;
      else if (!pm && in_ee && m_cmd == 8'h10) begin
        e_ew = 1; e_eaddr = sa[7:0]; e_data = sd;
      end else if (fl_t && (m_cmd == 8'h02 || m_cmd == 8'h03)) begin
        e_fw = (m_cmd == 8'h02); e_fpe = (m_cmd == 8'h03);
        e_faddr = {m_map, sa[14:0]}; e_data = sd;
      end
    end
    if (wr && a == 2'd1) begin
      if (open && !busy) begin
        if (known(d)) n_cmd = d;
        e_fce = (d == 8'h20); e_ece = (d == 8'h30);
      end else n_err = 1;
      n_cnt = 0;
    end else if (wr && a == 2'd0 && d == 8'h9D) n_cnt = 4;
    else if (ret && m_cnt > 0) n_cnt = m_cnt - 1;
    if (wr && a == 2'd2 && d[2]) n_err = 0;
    if (wr && a == 2'd3) n_map = d[1:0];
    m_fb = (m_fb && !fd) || e_fw || e_fpe || e_fce;
    m_eb = (m_eb && !ed) || e_ew || e_ece;
    m_cnt = n_cnt; m_cmd = n_cmd; m_err = n_err; m_map = n_map;
    @(negedge clk);
    chk(32'(fl_wr_stb), 32'(e_fw),  "R5 fl_wr_stb");
    chk(32'(fl_pe_stb), 32'(e_fpe), "R5 fl_pe_stb");
    chk(32'(ee_wr_stb), 32'(e_ew),  "R5 ee_wr_stb");
    chk(32'(fl_ce_stb), 32'(e_fce), "R4 fl_ce_stb");
    chk(32'(ee_ce_stb), 32'(e_ece), "R4 ee_ce_stb");
    chk(32'(st_reject), 32'(e_rej), "R9 st_reject");
    if (e_fw || e_fpe) begin
      chk(32'(fl_addr), 32'(e_faddr), "R8 fl_addr");
      chk(32'(wr_data), 32'(e_data), "R5 wr_data");
    end
    if (e_ew) chk(32'(ee_addr), 32'(e_eaddr), "R5 ee_addr");
  endtask

  task automatic idle(input logic ret = 0);
    cycle(0, 0, 0, ret, 0, 0, 0, 0, 0);
  endtask
  task automatic bwrite(input logic [1:0] a, input logic [7:0] d);
    cycle(1, a, d, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic store(input logic [15:0] sa, input logic pm);
    cycle(0, 0, 0, 0, 1, sa, pm, 0, 0);
  endtask
  task automatic fdone();
    cycle(0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask
  task automatic edone();
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask
  task automatic peek(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] got;
    bus_wr = 0; bus_addr = a; st_valid = 0; retire = 0; fl_done = 0; ee_done = 0;
    #1 got = bus_rdata;
    chk(32'(got), 32'(exp), req);
    cycle(0, a, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic unlock_cmd(input logic [7:0] c);
    bwrite(0, 8'h9D);
    bwrite(1, c);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] sa;
    logic [7:0] codes [8];
    codes = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h20, 8'h30, 8'h55};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R10)
    peek(0, 8'h00, "R10 reset key");
    peek(1, 8'h00, "R10 reset cmd");
    peek(2, 8'h00, "R10 reset status");
    peek(3, 8'h00, "R10 reset map");
    // unprotected write (R2)
    bwrite(1, 8'h02);
    peek(2, 8'h04, "R2 error set");
    peek(1, 8'h00, "R2 cmd unchanged");
    bwrite(2, 8'h04);
    peek(2, 8'h00, "R2 error cleared");
    // window expires after four retires (R1)
    bwrite(0, 8'h9D);
    repeat (4) idle(1);
    bwrite(1, 8'h02);
    peek(2, 8'h04, "R1 closed window error");
    peek(1, 8'h00, "R1 closed window cmd");
    bwrite(2, 8'h04);
    // three retires keep the window open (R1)
    bwrite(0, 8'h9D);
    repeat (3) idle(1);
    bwrite(1, 8'h02);
    peek(1, 8'h02, "R1 cmd accepted");
    peek(2, 8'h00, "R1 no error");
    // armed flash write, repeated (R5, R7)
    store(16'h8004, 0);
    chk(32'(fl_wr_stb), 1, "R5 first store");
    peek(2, 8'h01, "R7 flash busy");
    fdone();
    peek(2, 8'h00, "R7 flash idle");
    store(16'h8010, 0);
    chk(32'(fl_wr_stb), 1, "R5 armed persists");
    fdone();
    // unknown code ignored (R3)
    unlock_cmd(8'h55);
    peek(1, 8'h02, "R3 unknown ignored");
    peek(2, 8'h00, "R3 no error");
    // map select (R8)
    bwrite(3, 8'h03);
    peek(3, 8'h03, "R8 map readback");
    store(16'h8123, 1);
    chk(32'(fl_addr), 32'({2'b11, 15'h0123}), "R8 mapped address");
    fdone();
    // program-style store to EEPROM (R9)
    store(16'h1410, 1);
    chk(32'(st_reject), 1, "R9 reject");
    chk(32'(ee_wr_stb), 0, "R9 no ee strobe");
    // EEPROM write (R5)
    unlock_cmd(8'h10);
    store(16'h1420, 0);
    chk(32'(ee_wr_stb), 1, "R5 ee write");
    chk(32'(ee_addr), 32'h20, "R5 ee address");
    edone();
    // no-op disarms (R6)
    unlock_cmd(8'h01);
    store(16'h1420, 0);
    chk(32'(ee_wr_stb), 0, "R6 ee disarmed");
    store(16'h8000, 0);
    chk(32'(fl_wr_stb), 0, "R6 flash disarmed");
    // whole erases and busy error (R4, R2)
    unlock_cmd(8'h20);
    chk(32'(fl_ce_stb), 1, "R4 flash whole erase");
    peek(2, 8'h01, "R4 flash busy on launch");
    unlock_cmd(8'h30);
    peek(2, 8'h05, "R2 busy write error");
    peek(1, 8'h20, "R2 cmd kept");
    fdone();
    peek(2, 8'h04, "R7 busy cleared");
    bwrite(2, 8'h04);
    unlock_cmd(8'h30);
    chk(32'(ee_ce_stb), 1, "R4 ee whole erase");
    peek(2, 8'h02, "R4 ee busy on launch");
    edone();
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic ret, fd, ed;
      op  = int'($urandom % 16);
      ret = ($urandom % 4) == 0;
      fd  = ($urandom % 3) == 0;
      ed  = ($urandom % 3) == 0;
      case ($urandom % 3)
        0:       sa = 16'h1400 | 16'($urandom % 256);
        1:       sa = 16'h8000 | 16'($urandom & 32'h7fff);
        default: sa = 16'($urandom % 32'h1000);
      endcase
      if (op < 3)       cycle(1, 0, 8'h9D, ret, 0, 0, 0, fd, ed);
      else if (op == 3) cycle(1, 0, 8'($urandom), ret, 0, 0, 0, fd, ed);
      else if (op < 7)  cycle(1, 1, codes[$urandom % 8], ret, 0, 0, 0, fd, ed);
      else if (op == 7) cycle(1, 2, 8'($urandom), ret, 0, 0, 0, fd, ed);
      else if (op == 8) cycle(1, 3, 8'($urandom), ret, 0, 0, 0, fd, ed);
      else if (op < 14) cycle(0, 2'($urandom), 0, ret, 1, sa, 1'($urandom), fd, ed);
      else              cycle(0, 2'($urandom), 0, ret, 0, 0, 0, fd, ed);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule